// File: doc/BRIEF.md
# Two-Road Crossing Light Sequencer

This block runs the signals at a crossing of two roads, A and B. Each road has four lamps: go (green), turn (left-turn arrow), amber and red. The two roads take turns through a fixed cycle. Road A shows go, then turn, then amber, while road B stays red. Road B then runs the same three phases while road A stays red. A single countdown holds the seconds left in the current phase and moves with the lamps. The countdown is presented as two BCD digits and as two common-cathode seven-segment patterns.

All timing advances on a one-cycle strobe that arrives once per second. The phase lengths are parameters, with defaults of 45 s for go, 10 s for turn and 5 s for amber. The three phases of one road therefore add up to the other road's 60 s of red, and a full cycle takes 120 ticks. Reset is synchronous and active high.

Top module: `tl_xing_ctrl`

## Requirements
- R1: While reset is held and directly after it, road A shows go and the count reads 45. The lamp vector is {B.red, B.amber, B.turn, B.go, A.red, A.amber, A.turn, A.go}, bit 7 down to bit 0, so this state is 8'h81.
- R2: Road A passes through go (8'h81), turn (8'h82) and amber (8'h84) in that order. Road B shows red throughout all three phases.
- R3: After A's amber, road B passes through go (8'h18), turn (8'h28) and amber (8'h48) while road A shows red. Road A's go follows again, so the cycle repeats every 120 ticks.
- R4: The go phase lasts 45 ticks, the turn phase 10 ticks and the amber phase 5 ticks.
- R5: Count and lamps change only on a clock edge where tick_1s is high. With no tick they hold their values for any number of cycles.
- R6: On entering a phase the count shows that phase's full length. Each tick lowers it by one. The tick that arrives while the count is 1 moves to the next phase, so the count is never 0.
- R7: bcd_tens and bcd_ones hold the tens and units digit of the count.
- R8: Each segment output is ordered g..a (bit 6 = g, bit 0 = a), and a 1 lights a segment. The encodings for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R9: Each road lights exactly one lamp at all times. Whenever one road is not red, the other road is red.
- R10: Reset asserted in mid-cycle returns the block to the R1 state on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| lamps | output | 8 | Lamp drives, {B.red, B.amber, B.turn, B.go, A.red, A.amber, A.turn, A.go} |
| bcd_tens | output | 4 | Tens digit of the remaining seconds |
| bcd_ones | output | 4 | Units digit of the remaining seconds |
| seg_tens | output | 7 | Tens digit segments, g..a, 1 = lit |
| seg_ones | output | 7 | Units digit segments, g..a, 1 = lit |

## Verification
A wrong phase register appears on the lamp vector in the same cycle, as a wrong pattern or a road that loses its red. A counter that loads the wrong length or steps wrongly shows on the BCD and segment outputs one cycle after the tick that caused it. If the counter and the lamps fall out of step, the lamps change at the wrong tick, and this is seen within one phase length. Because every tick is checked across two full cycles, any such drift is caught at the first second in which it appears.

// File: rtl/tl_pkg.sv
package tl_pkg;

   typedef enum logic [2:0] {
      PH_A_GO    = 3'd0,
      PH_A_TURN  = 3'd1,
      PH_A_AMBER = 3'd2,
      PH_B_GO    = 3'd3,
      PH_B_TURN  = 3'd4,
      PH_B_AMBER = 3'd5
   } phase_t;

   typedef struct packed {
      logic red;
      logic amber;
      logic turn;
      logic go;
   } road_lamps_t;

   localparam int NUM_ROADS = 2;
   localparam int NUM_DIGITS = 2;

   function automatic phase_t phase_after(phase_t p);
      case (p)
         PH_A_GO:    return PH_A_TURN;
         PH_A_TURN:  return PH_A_AMBER;
         PH_A_AMBER: return PH_B_GO;
         PH_B_GO:    return PH_B_TURN;
         PH_B_TURN:  return PH_B_AMBER;
         default:    return PH_A_GO;
      endcase
   endfunction

   function automatic logic [6:0] seg_of(logic [3:0] d);
      case (d)
         4'd0: return 7'b0111111;
         4'd1: return 7'b0000110;
         4'd2: return 7'b1011011;
         4'd3: return 7'b1001111;
         4'd4: return 7'b1100110;
         4'd5: return 7'b1101101;
         4'd6: return 7'b1111101;
         4'd7: return 7'b0000111;
         4'd8: return 7'b1111111;
         4'd9: return 7'b1101111;
         default: return 7'b0000000;
      endcase
   endfunction

endpackage

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
   import tl_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   advance,
   output phase_t phase,
   output phase_t phase_next
);

   assign phase_next = phase_after(phase);

   always_ff @(posedge clk) begin
      if (rst)
         phase <= PH_A_GO;
      else if (advance)
         phase <= phase_next;
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !advance |=> $stable(phase)) else $error("phase moved without advance"); // R5

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      phase <= PH_B_AMBER) else $error("illegal phase"); // R3

endmodule

// File: rtl/tl_phase_timer.sv
module tl_phase_timer
   import tl_pkg::*;
#(
   parameter int GO_S    = 45,
   parameter int TURN_S  = 10,
   parameter int AMBER_S = 5,
   parameter int CNT_W   = 7
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  phase_t           nxt,
   output logic [CNT_W-1:0] count,
   output logic             last
);

   function automatic logic [CNT_W-1:0] length_of(phase_t p);
      case (p)
         PH_A_GO, PH_B_GO:     return CNT_W'(GO_S);
         PH_A_TURN, PH_B_TURN: return CNT_W'(TURN_S);
         default:              return CNT_W'(AMBER_S);
      endcase
   endfunction

   assign last = (count == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst)
         count <= CNT_W'(GO_S);
      else if (tick) begin
         if (last)
            count <= length_of(nxt);
         else
            count <= count - CNT_W'(1);
      end
   end

   AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
      count != '0) else $error("count reached zero"); // R6

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && !last) |=> (count == $past(count) - CNT_W'(1))) else $error("bad step"); // R6

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(count)) else $error("count moved without tick"); // R5

endmodule

// File: rtl/tl_lamp_map.sv
module tl_lamp_map
   import tl_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  phase_t      phase,
   output logic [7:0]  lamps
);

   road_lamps_t road [NUM_ROADS];

   for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
      localparam int BASE = 3 * r;
      logic active;
      logic [2:0] sub;
      always_comb begin
         active = (int'(phase) >= BASE) && (int'(phase) < BASE + 3);
         sub    = 3'(int'(phase) - BASE);
         road[r].go    = active && (sub == 3'd0);
         road[r].turn  = active && (sub == 3'd1);
         road[r].amber = active && (sub == 3'd2);
         road[r].red   = !active;
      end
      assign lamps[4*r +: 4] = road[r];
   end

   AST_CROSS_RED: assert property (@(posedge clk) disable iff (rst)
      (!lamps[3] -> lamps[7]) && (!lamps[7] -> lamps[3])) else $error("no road red"); // R9

   AST_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
      $countones(lamps[3:0]) == 1 && $countones(lamps[7:4]) == 1) else $error("lamp count"); // R9

endmodule

// File: rtl/tl_digit_disp.sv
module tl_digit_disp
   import tl_pkg::*;
#(
   parameter int CNT_W = 7
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] count,
   output logic [3:0]       bcd_tens,
   output logic [3:0]       bcd_ones,
   output logic [6:0]       seg_tens,
   output logic [6:0]       seg_ones
);

   logic [CNT_W-1:0] q10, r10;
   logic [3:0]       dig [NUM_DIGITS];
   logic [6:0]       seg [NUM_DIGITS];

   always_comb begin
      q10 = count / CNT_W'(10);
      r10 = count % CNT_W'(10);
   end

   assign dig[0] = r10[3:0];
   assign dig[1] = q10[3:0];

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
      assign seg[d] = seg_of(dig[d]);
   end

   assign bcd_ones = dig[0];
   assign bcd_tens = dig[1];
   assign seg_ones = seg[0];
   assign seg_tens = seg[1];

   AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
      bcd_tens <= 4'd9 && bcd_ones <= 4'd9) else $error("bcd out of range"); // R7

   AST_SEG_LIT: assert property (@(posedge clk) disable iff (rst)
      seg_ones != 7'd0 && seg_tens != 7'd0) else $error("blank digit"); // R8

endmodule

// File: rtl/tl_xing_ctrl.sv
module tl_xing_ctrl
   import tl_pkg::*;
#(
   parameter int GO_S    = 45,
   parameter int TURN_S  = 10,
   parameter int AMBER_S = 5
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_1s,
   output logic [7:0] lamps,
   output logic [3:0] bcd_tens,
   output logic [3:0] bcd_ones,
   output logic [6:0] seg_tens,
   output logic [6:0] seg_ones
);

   localparam int MAX_S = (GO_S > TURN_S) ? ((GO_S > AMBER_S) ? GO_S : AMBER_S)
                                          : ((TURN_S > AMBER_S) ? TURN_S : AMBER_S);
   localparam int CNT_W = $clog2(MAX_S + 1);

   initial begin
      AST_PARAM_RANGE: assert (GO_S >= 1 && TURN_S >= 1 && AMBER_S >= 1 && MAX_S <= 99)
         else $error("phase lengths must be 1..99"); // R4
   end

   phase_t           phase, phase_next;
   logic [CNT_W-1:0] count;
   logic             last;

   tl_phase_timer #(
      .GO_S(GO_S), .TURN_S(TURN_S), .AMBER_S(AMBER_S), .CNT_W(CNT_W)
   ) u_timer (
      .clk(clk), .rst(rst), .tick(tick_1s), .nxt(phase_next),
      .count(count), .last(last)
   );

   tl_phase_seq u_seq (
      .clk(clk), .rst(rst), .advance(tick_1s && last),
      .phase(phase), .phase_next(phase_next)
   );

   tl_lamp_map u_lamps (
      .clk(clk), .rst(rst), .phase(phase), .lamps(lamps)
   );

   tl_digit_disp #(.CNT_W(CNT_W)) u_disp (
      .clk(clk), .rst(rst), .count(count),
      .bcd_tens(bcd_tens), .bcd_ones(bcd_ones),
      .seg_tens(seg_tens), .seg_ones(seg_ones)
   );

endmodule

// File: tb/tl_xing_ctrl_tb.sv
module tl_xing_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   localparam logic [7:0] EXP_LAMPS [6] = '{8'h81, 8'h82, 8'h84, 8'h18, 8'h28, 8'h48};
   localparam int         EXP_DUR   [6] = '{45, 10, 5, 45, 10, 5};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick_1s = 1'b0;
   logic [7:0] lamps;
   logic [3:0] bcd_tens, bcd_ones;
   logic [6:0] seg_tens, seg_ones;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   tl_xing_ctrl u_dut (
      .clk(clk), .rst(rst), .tick_1s(tick_1s), .lamps(lamps),
      .bcd_tens(bcd_tens), .bcd_ones(bcd_ones),
      .seg_tens(seg_tens), .seg_ones(seg_ones)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] exp_seg(int d);
      case (d)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; 9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_state(string req, logic [7:0] el, int secs);
      chk(req, int'(lamps), int'(el));
      chk("R7 tens", int'(bcd_tens), secs / 10);
      chk("R7 ones", int'(bcd_ones), secs % 10);
      chk("R8 seg tens", int'(seg_tens), int'(exp_seg(secs / 10)));
      chk("R8 seg ones", int'(seg_ones), int'(exp_seg(secs % 10)));
      chk("R9 one lamp A", $countones(lamps[3:0]), 1);
      chk("R9 one lamp B", $countones(lamps[7:4]), 1);
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick_1s = 1'b1;
      @(negedge clk) tick_1s = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 while reset held
      chk_state("R1 in reset", 8'h81, 45);
      rst = 1'b0;
      @(negedge clk);
      chk_state("R1 after reset", 8'h81, 45);

      // R2 R3 R4 R6: table walk across two full cycles
      for (int c = 0; c < 2; c++) begin
         for (int p = 0; p < 6; p++) begin
            for (int s = EXP_DUR[p]; s >= 1; s--) begin
               chk_state(p < 3 ? "R2 lamps" : "R3 lamps", EXP_LAMPS[p], s);
               pulse_tick();
            end
         end
      end
      // R3 wrap back to A go
      chk_state("R3 wrap", 8'h81, 45);

      // R5 hold without tick
      pulse_tick();
      repeat (7) @(negedge clk);
      chk_state("R5 hold", 8'h81, 44);

      // R4 boundary: last go second then turn entry
      for (int i = 0; i < 43; i++) pulse_tick();
      chk_state("R4 go last second", 8'h81, 1);
      pulse_tick();
      chk_state("R6 turn entry", 8'h82, 10);

      // R10 mid-cycle reset
      for (int i = 0; i < 12; i++) pulse_tick();
      chk_state("R10 pre reset", 8'h84, 3);
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk_state("R10 after reset", 8'h81, 45);

      // R5 tick during reset is ignored
      @(negedge clk) begin rst = 1'b1; tick_1s = 1'b1; end
      @(negedge clk) begin rst = 1'b0; tick_1s = 1'b0; end
      chk_state("R5 tick in reset", 8'h81, 45);

      finish_run();
   end

endmodule